// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible face of a small serial port. A simple word-addressed bus reaches three 32-bit registers: a data word, a control word and a baud word. The data word carries two handshake flags next to the byte lane. Software queues a transmit byte by writing it with the send flag set. It collects a received byte by reading it and then writing the acknowledge flag. There are no FIFOs: one byte is held in each direction.

The control word holds the interface mode and two ready-override bits, which are driven straight to the line logic. It also holds a sticky overrun bit that is set when a byte arrives while the previous one is still unread. The baud word holds a 12-bit scale and a 16-bit step, which are driven to a separate baud generator.

Towards the serial shifters, the transmit side is a valid/ready stream. The front end presents `tx_valid` together with a byte. It keeps both steady until `tx_ready` is seen high at a clock edge, and frees the holding register on that edge. The receive side is valid-only: the shifter cannot be stalled, so every `rx_valid` pulse is consumed in its cycle. A pulse either fills the holding register or, if that register is occupied, is dropped and recorded as an overrun. Bus reads have no side effects. Read data appears on `bus_rdata` in the cycle after the read is presented and holds until the next read.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous active-low reset, the data word reads 0x0000_0200 (send flag high, everything else zero). The control and baud words read 0, `tx_valid` is 0, and all configuration outputs are 0.
- R2: A read presented at a clock edge returns, on `bus_rdata` after that edge, the register contents from before the edge. Word index = byte address bits 3:2: 0 is the data word, 1 the control word, 2 the baud word. Byte address bits 1:0 are ignored.
- R3: A write to the data word with bit 9 set, while the send flag is 1, captures bits 7:0. From the next cycle `tx_valid` is 1 with that byte on `tx_data`, and data-word bit 9 reads 0.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is unchanged. After an edge with both high, `tx_valid` is 0 and the send flag reads 1.
- R5: A data-word write with bit 9 clear, or with bit 9 set while the send flag is 0, leaves `tx_valid` and `tx_data` unchanged.
- R6: An `rx_valid` pulse while the receive flag (data-word bit 8) is 0 stores `rx_data`. Afterwards the data word reads that byte in bits 7:0 with bit 8 set.
- R7: A data-word write with bit 8 set clears the receive flag. A data-word write with bit 8 clear leaves the receive flag and byte unchanged.
- R8: An `rx_valid` pulse while the receive flag is 1 and no acknowledge is written in the same cycle keeps the held byte and sets overrun (control bit 12). If an acknowledge is written in the same cycle, the new byte is stored, the flag stays 1, and overrun is not set.
- R9: Writing 1 to control bit 12 clears overrun; writing 0 leaves it. If an overrun event happens in the same cycle as the clearing write, overrun ends up set.
- R10: A control write stores bits 3:2 as the interface mode (1 = DTE, 2 = DCE), bit 7 as transmit-ready override and bit 8 as receive-ready override. These drive `if_mode`, `tx_rdy_force` and `rx_rdy_force`. On read, every other control bit except 12 reads 0.
- R11: A baud write stores bits 27:16 as scale and bits 15:0 as step. These drive `baud_scale` and `baud_step`. Bits 31:28 read 0.
- R12: Word index 3 is unmapped: it reads 0, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Transmit byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte present for one cycle |
| rx_data | input | 8 | Received byte |
| if_mode | output | 2 | Interface mode |
| tx_rdy_force | output | 1 | Transmit-ready override |
| rx_rdy_force | output | 1 | Receive-ready override |
| baud_scale | output | 12 | Baud scale to the generator |
| baud_step | output | 16 | Baud step to the generator |

## Verification
The hardest cases to reach are the ones where two agents act on one flag in the same clock: a byte arriving in the very cycle software acknowledges the previous one, and an overrun arriving while software writes the clearing bit. Ordinary polled traffic almost never lines these up. The stimulus places them with directed steps that drive `rx_valid` and the bus write in the same cycle. A seeded random phase then overlaps arrivals, acknowledges, launches and `tx_ready` back-pressure freely, with every read compared against a bench model of the three words.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int BUS_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int RXF_BIT   = 8;
  localparam int TXF_BIT   = 9;
  localparam int MODE_LSB  = 2;
  localparam int MODE_W    = 2;
  localparam int TOV_BIT   = 7;
  localparam int ROV_BIT   = 8;
  localparam int OVR_BIT   = 12;
  localparam int STEP_LSB  = 0;
  localparam int SCALE_LSB = 16;
  localparam int DEF_STEP_W  = 16;
  localparam int DEF_SCALE_W = 12;

  typedef enum logic [1:0] {
    W_DATA = 2'd0,
    W_CTRL = 2'd1,
    W_BAUD = 2'd2,
    W_NONE = 2'd3
  } word_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              tx_force;
    logic              rx_force;
  } ctrl_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              wr_baud,
  output logic              rd_en,
  output word_e             word
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lo;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^bus_addr[1:0];

  always_comb begin
    if (idx == IDX_W'(0))      word = W_DATA;
    else if (idx == IDX_W'(1)) word = W_CTRL;
    else if (idx == IDX_W'(2)) word = W_BAUD;
    else                       word = W_NONE;
  end

  assign wr_data = bus_sel && bus_wr && (word == W_DATA);
  assign wr_ctrl = bus_sel && bus_wr && (word == W_CTRL);
  assign wr_baud = bus_sel && bus_wr && (word == W_BAUD);
  assign rd_en   = bus_sel && !bus_wr;
endmodule

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data
);
  logic              busy_q;
  logic [BYTE_W-1:0] byte_q;
  logic              take;

  // a launch is only honoured while the holding register is free
  assign take = load && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      byte_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      byte_q <= load_byte;
    end else if (busy_q && tx_ready) begin
      busy_q <= 1'b0;
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = byte_q;
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              ack,
  output logic              full,
  output logic [BYTE_W-1:0] held,
  output logic              lost
);
  logic              full_q;
  logic [BYTE_W-1:0] held_q;
  logic              room;

  // an acknowledge in the same cycle frees the slot for the arriving byte
  assign room = !full_q || ack;
  assign lost = rx_valid && !room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (rx_valid && room) begin
      full_q <= 1'b1;
      held_q <= rx_data;
    end else if (ack) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign held = held_q;
endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
  import uart_rf_pkg::*;
#(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16,
  localparam int CW     = SCALE_LSB + SCALE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_baud,
  input  logic [CW-1:0]      wdata,
  input  logic               lost,
  output ctrl_t              ctrl,
  output logic               ovr,
  output logic [SCALE_W-1:0] scale,
  output logic [STEP_W-1:0]  step
);
  ctrl_t              ctrl_q;
  logic               ovr_q;
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.mode     <= wdata[MODE_LSB +: MODE_W];
      ctrl_q.tx_force <= wdata[TOV_BIT];
      ctrl_q.rx_force <= wdata[ROV_BIT];
    end
  end

  // sticky: a new loss outranks a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                        ovr_q <= 1'b0;
    else if (lost)                     ovr_q <= 1'b1;
    else if (wr_ctrl && wdata[OVR_BIT]) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      step_q  <= '0;
    end else if (wr_baud) begin
      scale_q <= wdata[SCALE_LSB +: SCALE_W];
      step_q  <= wdata[STEP_LSB +: STEP_W];
    end
  end

  assign ctrl  = ctrl_q;
  assign ovr   = ovr_q;
  assign scale = scale_q;
  assign step  = step_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SCALE_W = DEF_SCALE_W,
  parameter int STEP_W  = DEF_STEP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [BYTE_W-1:0]  tx_data,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_data,
  output logic [MODE_W-1:0]  if_mode,
  output logic               tx_rdy_force,
  output logic               rx_rdy_force,
  output logic [SCALE_W-1:0] baud_scale,
  output logic [STEP_W-1:0]  baud_step
);
  localparam int CW = SCALE_LSB + SCALE_W;

  logic              wr_data, wr_ctrl, wr_baud, rd_en;
  word_e             word;
  logic              rx_full, lost, ovr_flag;
  logic [BYTE_W-1:0] rx_byte;
  ctrl_t             ctrl;
  logic [BUS_W-1:0]  rd_mux;
  logic [BUS_W-1:0]  rdata_q;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:CW];

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_data (wr_data),
    .wr_ctrl (wr_ctrl),
    .wr_baud (wr_baud),
    .rd_en   (rd_en),
    .word    (word)
  );

  uart_rf_txhold #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_data && bus_wdata[TXF_BIT]),
    .load_byte(bus_wdata[BYTE_W-1:0]),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );

  uart_rf_rxhold #(.BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .ack     (wr_data && bus_wdata[RXF_BIT]),
    .full    (rx_full),
    .held    (rx_byte),
    .lost    (lost)
  );

  uart_rf_cfg #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wr_baud(wr_baud),
    .wdata  (bus_wdata[CW-1:0]),
    .lost   (lost),
    .ctrl   (ctrl),
    .ovr    (ovr_flag),
    .scale  (baud_scale),
    .step   (baud_step)
  );

  always_comb begin
    rd_mux = '0;
    case (word)
      W_DATA: begin
        rd_mux[BYTE_W-1:0] = rx_byte;
        rd_mux[RXF_BIT]    = rx_full;
        rd_mux[TXF_BIT]    = !tx_valid;
      end
      W_CTRL: begin
        rd_mux[MODE_LSB +: MODE_W] = ctrl.mode;
        rd_mux[TOV_BIT]            = ctrl.tx_force;
        rd_mux[ROV_BIT]            = ctrl.rx_force;
        rd_mux[OVR_BIT]            = ovr_flag;
      end
      W_BAUD: begin
        rd_mux[STEP_LSB +: STEP_W]   = baud_step;
        rd_mux[SCALE_LSB +: SCALE_W] = baud_scale;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign if_mode      = ctrl.mode;
  assign tx_rdy_force = ctrl.tx_force;
  assign rx_rdy_force = ctrl.rx_force;
endmodule

// File: rtl/uart_rf_checker.sv
module uart_rf_checker
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [BYTE_W-1:0]  tx_data,
  input logic               rx_valid,
  input logic               rx_full,
  input logic               ovr_flag,
  input logic [SCALE_W-1:0] baud_scale,
  input logic [STEP_W-1:0]  baud_step
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             dwr, ack;
  assign idx = bus_addr[ADDR_W-1:2];
  assign dwr = bus_sel && bus_wr && (idx == IDX_W'(0));
  assign ack = dwr && bus_wdata[RXF_BIT];

  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && bus_wdata[TXF_BIT] && !tx_valid |=> tx_valid && (tx_data == $past(bus_wdata[BYTE_W-1:0]))); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid); // R4
  AST_RX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !rx_valid |=> !rx_full); // R7
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full && !ack |=> ovr_flag && rx_full); // R8
  AST_RX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_full); // R6
  AST_BAUD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && (idx == IDX_W'(2)) |=>
      (baud_step == $past(bus_wdata[STEP_LSB +: STEP_W])) &&
      (baud_scale == $past(bus_wdata[SCALE_LSB +: SCALE_W]))); // R11
  AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && (idx > IDX_W'(2)) |=> bus_rdata == '0); // R12
endmodule

bind uart_regfile uart_rf_checker #(
  .ADDR_W(ADDR_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rx_valid  (rx_valid),
  .rx_full   (rx_full),
  .ovr_flag  (ovr_flag),
  .baud_scale(baud_scale),
  .baud_step (baud_step)
);

// File: tb/uart_regfile_bench.sv
`timescale 1ns/1ps
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [1:0]  if_mode;
  logic        tx_rdy_force, rx_rdy_force;
  logic [11:0] baud_scale;
  logic [15:0] baud_step;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model of the registers, built from the requirements
  bit        m_txf, m_rxf, m_ovr, m_tov, m_rov;
  bit [7:0]  m_txb, m_rxb;
  bit [1:0]  m_mode;
  bit [11:0] m_scale;
  bit [15:0] m_step;

  always #5 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .if_mode(if_mode),
    .tx_rdy_force(tx_rdy_force), .rx_rdy_force(rx_rdy_force),
    .baud_scale(baud_scale), .baud_step(baud_step)
  );

  function automatic bit [31:0] exp_word(input bit [3:0] a);
    bit [31:0] w = '0;
    case (a[3:2])
      2'd0: begin w[7:0] = m_rxb; w[8] = m_rxf; w[9] = !m_txf; end
      2'd1: begin w[3:2] = m_mode; w[7] = m_tov; w[8] = m_rov; w[12] = m_ovr; end
      2'd2: begin w[15:0] = m_step; w[27:16] = m_scale; end
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_txf = 0; m_rxf = 0; m_ovr = 0; m_tov = 0; m_rov = 0;
    m_txb = 0; m_rxb = 0; m_mode = 0; m_scale = 0; m_step = 0;
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(input string tag, input bit sel, input bit wr, input bit [3:0] a,
                      input bit [31:0] wd, input bit rxv, input bit [7:0] rxd, input bit txr);
    bit [31:0] exp_rd;
    bit rd, dw, ack, lost;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rxv; rx_data = rxd; tx_ready = txr;
    rd = sel && !wr;
    exp_rd = exp_word(a);
    dw = sel && wr && (a[3:2] == 2'd0);
    ack = dw && wd[8];
    lost = rxv && m_rxf && !ack;
    if (dw && wd[9] && !m_txf) begin m_txf = 1; m_txb = wd[7:0]; end
    else if (m_txf && txr) m_txf = 0;
    if (rxv && !lost) begin m_rxf = 1; m_rxb = rxd; end
    else if (ack) m_rxf = 0;
    if (lost) m_ovr = 1;
    else if (sel && wr && a[3:2] == 2'd1 && wd[12]) m_ovr = 0;
    if (sel && wr && a[3:2] == 2'd1) begin m_mode = wd[3:2]; m_tov = wd[7]; m_rov = wd[8]; end
    if (sel && wr && a[3:2] == 2'd2) begin m_scale = wd[27:16]; m_step = wd[15:0]; end
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    if (rd) check(tag, "rdata", bus_rdata, exp_rd);
    check(tag, "tx_valid", {31'b0, tx_valid}, {31'b0, m_txf});
    if (m_txf) check(tag, "tx_data", {24'b0, tx_data}, {24'b0, m_txb});
    check(tag, "cfg", {12'b0, if_mode, tx_rdy_force, rx_rdy_force, baud_step},
                      {12'b0, m_mode, m_tov, m_rov, m_step});
    check(tag, "scale", {20'b0, baud_scale}, {20'b0, m_scale});
  endtask

  task automatic wr(input string tag, input bit [3:0] a, input bit [31:0] d);
    step(tag, 1, 1, a, d, 0, 0, 0);
  endtask
  task automatic rd(input string tag, input bit [3:0] a);
    step(tag, 1, 0, a, 0, 0, 0, 0);
  endtask
  task automatic rx(input string tag, input bit [7:0] d);
    step(tag, 0, 0, 0, 0, 1, d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 4'h0); rd("R1", 4'h4); rd("R1", 4'h8);
    // R3 launch, R5 ignored writes
    wr("R3", 4'h0, 32'h0000_02A5); rd("R3", 4'h0);
    wr("R5", 4'h0, 32'h0000_00FF); wr("R5", 4'h0, 32'h0000_023C);
    // R4 back-pressure then hand-off
    repeat (3) step("R4", 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1); rd("R4", 4'h0);
    // R6 capture, R7 acknowledge rules
    rx("R6", 8'h5C); rd("R6", 4'h0);
    wr("R7", 4'h0, 32'h0000_0000); rd("R7", 4'h0);
    wr("R7", 4'h0, 32'h0000_0100); rd("R7", 4'h0);
    // R8 overrun keeps old byte; same-cycle ack takes the new one
    rx("R8", 8'h11); rx("R8", 8'h22); rd("R8", 4'h0); rd("R8", 4'h4);
    step("R8", 1, 1, 4'h0, 32'h0000_0100, 1, 8'h33, 0); rd("R8", 4'h0);
    // R9 clear, then set beats clear
    wr("R9", 4'h4, 32'h0000_1000); rd("R9", 4'h4);
    step("R9", 1, 1, 4'h4, 32'h0000_1000, 1, 8'h44, 0); rd("R9", 4'h4);
    // R10 control fields
    wr("R10", 4'h4, 32'hFFFF_EFFF); rd("R10", 4'h4);
    wr("R10", 4'h4, 32'h0000_0008); rd("R10", 4'h4);
    wr("R10", 4'h4, 32'h0000_0004); rd("R10", 4'h4);
    // R11 baud fields
    wr("R11", 4'h8, 32'hFFFF_FFFF); rd("R11", 4'h8);
    wr("R11", 4'h8, 32'h0123_4567); rd("R11", 4'h8);
    // R12 unmapped word; R2 low address bits ignored
    wr("R12", 4'hC, 32'hFFFF_FFFF); rd("R12", 4'hC); rd("R12", 4'hF);
    rd("R2", 4'h9); rd("R2", 4'h3); rd("R2", 4'h6);
    // R2 random mix
    for (int i = 0; i < 4000; i++) begin
      bit [3:0] a = 4'($urandom_range(0, 15));
      bit [31:0] d = $urandom;
      bit s = ($urandom_range(0, 3) != 0);
      step("R2", s, s && $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 1) == 1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule